// File: doc/BRIEF.md
# Transmit Line Overhead Inserter

This block sits in a byte-serial transmit path carrying an STS-3/STM-1 frame, one byte per clock, with a marker on the first byte of each frame. It counts frame positions and rewrites a few line overhead bytes on the way through. Every byte leaves the block exactly one clock after it enters. The frame-start marker is delayed by the same clock.

Two rewrites are performed. The first forces the line remote defect indication code into the K2 byte. Either a control register bit or an external request can ask for it. The second picks the content of the express orderwire triple in the last row. The orderwire byte comes from a local orderwire input, from the upstream stream, or is zero. Its two companion bytes are zero-filled unless a bypass applies. The same 8-bit control register also holds six further bits. They are stored and read back only.

Top module: `tx_line_oh_inserter`

## Requirements
- R1: The control register resets to 8'h00 and reads back the last value written. Bit 0 is the RDI force bit, bit 1 is the orderwire-forward bit, bit 6 is the upper-byte bypass bit.
- R2: When control bit 0 is one, the K2 byte leaves with its three least significant bits set to 3'b110 and its upper five bits unchanged. The K2 byte is row 5, column 7, counting from 1.
- R3: When `ext_rdi` is high during the K2 byte, the same 3'b110 code is inserted even with control bit 0 at zero.
- R4: With neither RDI source active, the K2 byte passes unchanged.
- R5: The orderwire byte (row 9, column 7) is forwarded from `in_byte` when control bit 1, `in_pass` or `in_ohen` is high. Otherwise it is replaced by `ow_byte`.
- R6: The two bytes after it (row 9, columns 8 and 9) are driven to 8'h00, unless `in_pass` is high for that byte or control bit 6 is one, in which case they are forwarded.
- R7: `in_sof` marks row 1, column 1. Positions advance over 9 rows of 270 columns and wrap. A new `in_sof` restarts the count from any position. Before the first `in_sof` no byte is modified.
- R8: `out_byte` and `out_sof` follow the input by exactly one clock. All bytes outside the positions above are unchanged. Both outputs are zero in reset.
- R9: A register write takes effect from the byte after the one presented with the write.
- R10: Control bits 2 to 5 and 7 are stored only and change no output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming frame byte |
| in_sof | input | 1 | First byte of frame marker |
| in_pass | input | 1 | Per-byte pass-through request |
| in_ohen | input | 1 | Overhead-enable request, forwards the orderwire byte |
| ow_byte | input | 8 | Local orderwire byte |
| ext_rdi | input | 1 | External line RDI request |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| out_byte | output | 8 | Outgoing frame byte |
| out_sof | output | 1 | First byte marker, delayed one clock |

## Verification
On every cycle the assertions check several things. The RDI code lands on K2 whenever either source is active, and K2 is left intact otherwise. The zero fill and the local orderwire source appear when their conditions hold. The column counter wraps, and register writes land one cycle later. Whole-frame placement is shown only by the bench scenarios, which compare every output byte against an independent position model. These scenarios cover the unframed start, a mid-frame resync, a write on the orderwire byte itself and the stored-only bits.

// File: rtl/olh_pkg.sv
package olh_pkg;

  // control register, bit 7 down to bit 0
  typedef struct packed {
    logic spare7;
    logic ubt;
    logic spare5;
    logic spare4;
    logic spare3;
    logic spare2;
    logic dow;
    logic rdi;
  } olh_ctrl_t;

  localparam logic [2:0] RDI_CODE = 3'b110;

  // K2 with line RDI: upper five bits kept, low three forced
  function automatic logic [7:0] k2_with_rdi(input logic [7:0] b);
    return {b[7:3], RDI_CODE};
  endfunction

endpackage

// File: rtl/olh_ctrl_reg.sv
module olh_ctrl_reg
  import olh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output olh_ctrl_t  ctrl
);
  olh_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= olh_ctrl_t'(wdata);
  end

  assign ctrl = ctrl_q;

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (8'(ctrl_q) == $past(wdata)));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q));
endmodule

// File: rtl/olh_frame_pos.sv
module olh_frame_pos #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          framed
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          framed_q;

  // position of the byte now at the input
  assign row    = sof ? '0 : row_q;
  assign col    = sof ? '0 : col_q;
  assign framed = sof | framed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      framed_q <= 1'b0;
    end else if (framed) begin
      framed_q <= 1'b1;
      if (col == LAST_COL) begin
        col_q <= '0;
        row_q <= (row == LAST_ROW) ? '0 : row + 1'b1;
      end else begin
        col_q <= col + 1'b1;
        row_q <= row;
      end
    end
  end

  p_col_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_q && !sof && col_q == LAST_COL) |=> (col_q == '0));
  p_sof_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (col_q == CW'(1) && row_q == '0 && framed_q));
endmodule

// File: rtl/olh_byte_sel.sv
module olh_byte_sel
  import olh_pkg::*;
#(
  parameter int RW = 4,
  parameter int CW = 9,
  parameter int K2_ROW = 4,
  parameter int OW_ROW = 8,
  parameter int TRIPLE_COL = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          framed,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic [7:0]    in_byte,
  input  logic          in_sof,
  input  logic          in_pass,
  input  logic          in_ohen,
  input  logic [7:0]    ow_byte,
  input  logic          ext_rdi,
  input  olh_ctrl_t     ctrl,
  output logic [7:0]    out_byte,
  output logic          out_sof
);
  // named position and decision events
  logic at_k2, at_e2, at_fill, rdi_act, e2_up, fill_keep;
  logic [7:0] nxt;

  assign at_k2   = framed && row == RW'(K2_ROW) && col == CW'(TRIPLE_COL);
  assign at_e2   = framed && row == RW'(OW_ROW) && col == CW'(TRIPLE_COL);
  assign at_fill = framed && row == RW'(OW_ROW) &&
                   (col == CW'(TRIPLE_COL + 1) || col == CW'(TRIPLE_COL + 2));
  assign rdi_act   = ctrl.rdi | ext_rdi;
  assign e2_up     = ctrl.dow | in_pass | in_ohen;
  assign fill_keep = in_pass | ctrl.ubt;

  always_comb begin
    nxt = in_byte;
    if (at_k2 && rdi_act)         nxt = k2_with_rdi(in_byte);
    else if (at_e2 && !e2_up)     nxt = ow_byte;
    else if (at_fill && !fill_keep) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= '0;
      out_sof  <= 1'b0;
    end else begin
      out_byte <= nxt;
      out_sof  <= in_sof;
    end
  end

  p_k2_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_k2 && ctrl.rdi) |=> (out_byte == {$past(in_byte[7:3]), 3'b110}));
  p_k2_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_k2 && ext_rdi) |=> (out_byte[2:0] == 3'b110));
  p_k2_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_k2 && !ctrl.rdi && !ext_rdi) |=> (out_byte == $past(in_byte)));
  p_e2_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_e2 && !ctrl.dow && !in_pass && !in_ohen) |=> (out_byte == $past(ow_byte)));
  p_fill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_fill && !in_pass && !ctrl.ubt) |=> (out_byte == 8'h00));
  p_plain_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_k2 && !at_e2 && !at_fill) |=> (out_byte == $past(in_byte)));
endmodule

// File: rtl/tx_line_oh_inserter.sv
module tx_line_oh_inserter
  import olh_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int K2_ROW = 4,
  parameter int OW_ROW = 8,
  parameter int TRIPLE_COL = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_sof,
  input  logic       in_pass,
  input  logic       in_ohen,
  input  logic [7:0] ow_byte,
  input  logic       ext_rdi,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [7:0] out_byte,
  output logic       out_sof
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  olh_ctrl_t     ctrl;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          framed;

  olh_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .ctrl(ctrl)
  );

  olh_frame_pos #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk(clk), .rst_n(rst_n), .sof(in_sof), .row(row), .col(col), .framed(framed)
  );

  olh_byte_sel #(
    .RW(RW), .CW(CW), .K2_ROW(K2_ROW), .OW_ROW(OW_ROW), .TRIPLE_COL(TRIPLE_COL)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .framed(framed), .row(row), .col(col),
    .in_byte(in_byte), .in_sof(in_sof), .in_pass(in_pass), .in_ohen(in_ohen),
    .ow_byte(ow_byte), .ext_rdi(ext_rdi), .ctrl(ctrl),
    .out_byte(out_byte), .out_sof(out_sof)
  );

  assign reg_rdata = 8'(ctrl);
endmodule

// File: tb/sim_tx_line_oh_inserter.sv
module sim_tx_line_oh_inserter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_sof, in_pass, in_ohen, ext_rdi, reg_we, out_sof;
  logic [7:0] in_byte, ow_byte, reg_wdata, reg_rdata, out_byte;

  tx_line_oh_inserter u0 (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_sof(in_sof),
    .in_pass(in_pass), .in_ohen(in_ohen), .ow_byte(ow_byte), .ext_rdi(ext_rdi),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_byte(out_byte), .out_sof(out_sof)
  );

  int errs = 0, checks = 0, cyc = 0;
  // reference model state
  int mrow = 0, mcol = 0;
  bit mframed = 0;
  logic [7:0] mctrl = 8'h00;
  logic [7:0] exp_b;
  bit exp_s, exp_valid = 0;
  string exp_tag;
  // scenario knobs
  int g_pass_col = -1, g_ohen_col = -1, g_we_col = -1;
  bit g_ext = 0;
  logic [7:0] g_we_val = 8'h00;
  string g_note = "";

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit sof, bit pass, bit ohen, bit we, logic [7:0] wd);
    int r, c;
    bit f;
    @(negedge clk);
    if (exp_valid) begin
      chk(exp_tag, out_byte, exp_b);
      chk("R8 sof delay", {7'b0, out_sof}, {7'b0, exp_s});
    end
    cyc++;
    in_byte = 8'(cyc * 37 + 11);
    ow_byte = 8'(cyc * 5 + 90);
    in_sof = sof; in_pass = pass; in_ohen = ohen; ext_rdi = g_ext;
    reg_we = we; reg_wdata = wd;
    if (sof) begin r = 0; c = 0; f = 1; end
    else begin r = mrow; c = mcol; f = mframed; end
    exp_b = in_byte; exp_s = sof; exp_tag = {"R8 plain ", g_note};
    if (!f) exp_tag = "R7 unframed";
    else if (r == 4 && c == 6) begin
      if (mctrl[0])   begin exp_b = {in_byte[7:3], 3'b110}; exp_tag = "R2 K2 reg"; end
      else if (g_ext) begin exp_b = {in_byte[7:3], 3'b110}; exp_tag = "R3 K2 ext"; end
      else exp_tag = "R4 K2 keep";
    end else if (r == 8 && c == 6) begin
      exp_tag = {"R5 E2 ", g_note};
      if (!(mctrl[1] || pass || ohen)) exp_b = ow_byte;
    end else if (r == 8 && (c == 7 || c == 8)) begin
      exp_tag = {"R6 fill ", g_note};
      if (!(pass || mctrl[6])) exp_b = 8'h00;
    end
    if (f) begin
      c++;
      if (c == 270) begin c = 0; r = (r + 1) % 9; end
    end
    mrow = r; mcol = c; mframed = f;
    if (we) mctrl = wd;
    exp_valid = 1;
  endtask

  task automatic run_bytes(int n, bit first_sof);
    for (int i = 0; i < n; i++) begin
      bit s = first_sof && (i == 0);
      int r = s ? 0 : mrow;
      int c = s ? 0 : mcol;
      bit row9 = (r == 8);
      bit wr = row9 && (c == g_we_col);
      step(s, row9 && c == g_pass_col, row9 && c == g_ohen_col, wr, g_we_val);
    end
  endtask

  task automatic write_reg(logic [7:0] v, string tag);
    step(0, 0, 0, 1, v);
    step(0, 0, 0, 0, 8'h00);
    chk(tag, reg_rdata, v);
  endtask

  initial begin
    #(4 * 190000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; in_byte = 0; in_sof = 0; in_pass = 0; in_ohen = 0;
    ow_byte = 0; ext_rdi = 0; reg_we = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R8 reset out", out_byte, 8'h00);
    chk("R8 reset sof", {7'b0, out_sof}, 8'h00);
    rst_n = 1;
    // R7: no rewrite before framing, even with RDI forced
    write_reg(8'h01, "R1 readback rdi");
    run_bytes(3000, 0);
    // R4 R5 R6: defaults
    write_reg(8'h00, "R1 readback zero");
    run_bytes(2430, 1);
    // R2: register RDI
    write_reg(8'h01, "R1 readback rdi");
    run_bytes(2430, 1);
    // R3: external RDI only
    write_reg(8'h00, "R1 readback zero");
    g_ext = 1; run_bytes(2430, 1); g_ext = 0;
    // R5 R6: forward orderwire, pass one fill byte
    write_reg(8'h02, "R1 readback dow");
    g_pass_col = 7; run_bytes(2430, 1); g_pass_col = -1;
    // R5 R6: overhead-enable on E2, bypass bit keeps fills
    write_reg(8'h40, "R1 readback ubt");
    g_ohen_col = 6; run_bytes(2430, 1); g_ohen_col = -1;
    // R10: stored-only bits leave every byte untouched
    write_reg(8'hBC, "R10 readback spare bits");
    run_bytes(2430, 1);
    // R9: write of bypass bit presented with the E2 byte
    write_reg(8'h00, "R1 readback zero");
    g_note = "R9"; g_we_col = 6; g_we_val = 8'h40;
    run_bytes(2430, 1);
    g_we_col = -1; g_note = "";
    chk("R9 readback", reg_rdata, 8'h40);
    // R7: resync mid-frame, RDI on to mark K2
    write_reg(8'h01, "R1 readback rdi");
    run_bytes(1500, 1);
    run_bytes(2440, 1);
    step(0, 0, 0, 0, 8'h00);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule